// File: doc/BRIEF.md
# DRAM Refresh Credit Scheduler

This block tells a DDR SDRAM command arbiter when an AUTO REFRESH has to go out. An interval timer, sized from the clock frequency and the target average refresh period, produces one tick per period. Each tick adds one owed refresh to a credit counter. Each refresh that is actually issued removes one. The arbiter can therefore keep serving traffic while refreshes pile up. Once the postponement limit is reached, the request turns urgent. A grant given at that point keeps every gap between refreshes within nine average periods.

The request and the grant form a valid/ready pair. `ref_req` is the valid and `ref_gnt` is the ready. A refresh is taken on a rising edge where both are high. The arbiter may hold `ref_gnt` low for as long as it likes, which is back-pressure. The request then simply stays up and keeps accumulating credit. A grant while `ref_req` is low is ignored. A taken refresh produces a registered one-cycle command strobe. It also starts a recovery window of `TRFC_CYC` cycles. During that window the block reports busy, asks for CKE to be held high, and withholds its request. Each refresh is commanded on its own, and one strobe always stands for exactly one refresh.

Top module: `refresh_credit_sched`

## Requirements
- R1: While reset is held and in the cycle after its release, `ref_req`, `ref_urgent`, `ref_busy`, `cmd_ref` and `cke_keep` are all 0, and the owed count is 0.
- R2: An interval tick occurs every TICK_CYCLES = CLK_KHZ*INTERVAL_NS/1e6 cycles, the first on edge TICK_CYCLES after reset release. Each tick raises the owed count by one, so `ref_req` first goes high in the cycle after that edge.
- R3: `ref_urgent` is 1 exactly when the owed count is at least DEFER_MAX (default 8); with 1 to DEFER_MAX-1 owed only the polite request shows.
- R4: A refresh is taken on a rising edge with `ref_req` and `ref_gnt` both high. `cmd_ref` is then 1 for exactly the following cycle, and the owed count drops by one.
- R5: `ref_gnt` while `ref_req` is low has no effect: no strobe, owed count unchanged.
- R6: After a refresh is taken, `ref_busy` and `cke_keep` are 1 for exactly TRFC_CYC cycles starting with the strobe cycle. `ref_req` is 0 during that time, so consecutive refreshes are at least TRFC_CYC+1 cycles apart.
- R7: The owed count saturates at DEFER_MAX+1. A tick and a taken refresh on the same edge leave the count unchanged.
- R8: With the grant held high, the long-run rate is one refresh per interval. No gap between consecutive strobes exceeds nine intervals when urgent requests are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grant (ready) for the refresh request |
| ref_req | output | 1 | Refresh request (valid): at least one refresh owed and no recovery running |
| ref_urgent | output | 1 | Postponement limit reached; grant before the next tick |
| ref_busy | output | 1 | Refresh recovery window in progress |
| cmd_ref | output | 1 | One-cycle AUTO REFRESH command strobe |
| cke_keep | output | 1 | Clock enable must be held high (refresh period) |

## Verification
The grant is first withheld across ten intervals, so the credit passes the urgency threshold and then the saturation point. Releasing the grant after that drains exactly DEFER_MAX+1 refreshes, which tells saturation apart from plain counting. A long stretch of continuous grant checks the one-per-interval rate and the recovery spacing. Grants given with nothing owed must produce nothing. A single-cycle grant placed on a tick edge separates the simultaneous tick-and-take case from an off-by-one in the counter.

// File: rtl/refsched_pkg.sv
`timescale 1ns/1ps
package refsched_pkg;

  // Request level presented towards the arbiter
  typedef enum logic [1:0] {
    LVL_IDLE   = 2'd0,
    LVL_POLITE = 2'd1,
    LVL_URGENT = 2'd2
  } ref_level_e;

  // Cycles per interval from clock in kHz and interval in ns
  function automatic int unsigned cycles_per_interval(input int unsigned clk_khz,
                                                      input int unsigned interval_ns);
    longint unsigned prod;
    prod = longint'(clk_khz) * longint'(interval_ns);
    return int'(prod / 64'd1000000);
  endfunction

endpackage

// File: rtl/refsched_interval_timer.sv
`timescale 1ns/1ps
module refsched_interval_timer #(
  parameter int unsigned TICK_CYCLES = 3125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (TICK_CYCLES <= 1) begin : g_every_cycle
      // Degenerate case: every clock edge after reset is a tick
      logic unused_clk;
      assign unused_clk = clk;
      assign tick_o = rst_n;
    end else begin : g_counter
      localparam int unsigned W = $clog2(TICK_CYCLES);
      localparam logic [W-1:0] RELOAD = W'(TICK_CYCLES - 1);

      logic [W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= RELOAD;
        end else if (cnt_q == '0) begin
          cnt_q <= RELOAD;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      assign tick_o = (cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/refsched_credit.sv
`timescale 1ns/1ps
module refsched_credit
  import refsched_pkg::*;
#(
  parameter int unsigned DEFER_MAX = 8,
  parameter int unsigned CW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          take_i,
  output logic [CW-1:0] owed_o,
  output ref_level_e    level_o
);

  localparam logic [CW:0]   SAT_W = (CW+1)'(DEFER_MAX + 1);
  localparam logic [CW-1:0] SAT   = CW'(DEFER_MAX + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEFER_MAX);

  logic [CW-1:0] owed_q;
  logic [CW:0]   sum;
  logic [CW-1:0] owed_d;

  // One step: add the tick, remove the taken refresh, clamp at the cap
  always_comb begin
    sum = {1'b0, owed_q};
    if (tick_i) begin
      sum = sum + 1'b1;
    end
    if (take_i && (sum != '0)) begin
      sum = sum - 1'b1;
    end
    if (sum > SAT_W) begin
      owed_d = SAT;
    end else begin
      owed_d = sum[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else begin
      owed_q <= owed_d;
    end
  end

  always_comb begin
    if (owed_q == '0) begin
      level_o = LVL_IDLE;
    end else if (owed_q >= LIMIT) begin
      level_o = LVL_URGENT;
    end else begin
      level_o = LVL_POLITE;
    end
  end

  assign owed_o = owed_q;

endmodule

// File: rtl/refsched_recovery.sv
`timescale 1ns/1ps
module refsched_recovery #(
  parameter int unsigned TRFC_CYC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned W = (TRFC_CYC < 2) ? 1 : $clog2(TRFC_CYC + 1);
  localparam logic [W-1:0] LOAD = W'(TRFC_CYC);

  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (start_i) begin
      left_q <= LOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_o = (left_q != '0);

endmodule

// File: rtl/refresh_credit_sched.sv
`timescale 1ns/1ps
module refresh_credit_sched
  import refsched_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 200000,
  parameter int unsigned INTERVAL_NS = 15625,
  parameter int unsigned TRFC_CYC    = 14,
  parameter int unsigned DEFER_MAX   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic ref_busy,
  output logic cmd_ref,
  output logic cke_keep
);

  localparam int unsigned TICK_CYCLES = cycles_per_interval(CLK_KHZ, INTERVAL_NS);
  localparam int unsigned CW          = $clog2(DEFER_MAX + 2);

  logic          tick;
  logic          take;
  logic          busy;
  logic [CW-1:0] owed;
  ref_level_e    level;
  logic          cmd_q;

  refsched_interval_timer #(
    .TICK_CYCLES(TICK_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(tick)
  );

  refsched_credit #(
    .DEFER_MAX(DEFER_MAX),
    .CW       (CW)
  ) u_credit (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .take_i (take),
    .owed_o (owed),
    .level_o(level)
  );

  refsched_recovery #(
    .TRFC_CYC(TRFC_CYC)
  ) u_recovery (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(take),
    .busy_o (busy)
  );

  // Valid/ready: request shown only when something is owed and the bus is free
  assign ref_req = (level != LVL_IDLE) && !busy;
  assign take    = ref_req && ref_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
    end else begin
      cmd_q <= take;
    end
  end

  assign ref_urgent = (level == LVL_URGENT);
  assign ref_busy   = busy;
  assign cmd_ref    = cmd_q;
  assign cke_keep   = busy;

endmodule

// File: rtl/refsched_chk.sv
`timescale 1ns/1ps
module refsched_chk #(
  parameter int unsigned DEFER_MAX = 8,
  parameter int unsigned CW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          ref_urgent,
  input logic          ref_busy,
  input logic          cmd_ref,
  input logic          tick,
  input logic [CW-1:0] owed
);

  localparam logic [CW-1:0] CAP = CW'(DEFER_MAX + 1);

  // R4
  issue_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> cmd_ref);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ref |=> !cmd_ref);

  // R5
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_req |=> !cmd_ref);

  // R6
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ref |-> ref_busy);

  // R6
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !ref_req);

  // R7
  owed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= CAP);

  // R3
  urgent_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_urgent) |-> $past(tick));

  // R2
  owed_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed > $past(owed)) |-> $past(tick));

endmodule

bind refresh_credit_sched refsched_chk #(
  .DEFER_MAX(DEFER_MAX),
  .CW       (CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .ref_urgent(ref_urgent),
  .ref_busy  (ref_busy),
  .cmd_ref   (cmd_ref),
  .tick      (tick),
  .owed      (owed)
);

// File: tb/refresh_credit_sched_test.sv
`timescale 1ns/1ps
module refresh_credit_sched_test;

  localparam int TICK = 100;  // 200 MHz * 500 ns
  localparam int TRFC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_urgent, ref_busy, cmd_ref, cke_keep;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int exp_q[$];
  int last_cmd = -1;
  int rate_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  refresh_credit_sched #(
    .CLK_KHZ    (200000),
    .INTERVAL_NS(500),
    .TRFC_CYC   (TRFC),
    .DEFER_MAX  (8)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_gnt   (ref_gnt),
    .ref_req   (ref_req),
    .ref_urgent(ref_urgent),
    .ref_busy  (ref_busy),
    .cmd_ref   (cmd_ref),
    .cke_keep  (cke_keep)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: pop expected strobe cycles as the design emits them
  always @(negedge clk) begin
    if (rst_n && cmd_ref) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected strobe", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R4 strobe cycle", cyc, e);
      end
      if (last_cmd >= 0)
        check((cyc - last_cmd) <= 9 * TICK, "R8 gap", cyc - last_cmd, 9 * TICK);
      last_cmd = cyc;
      if (cyc >= 11 * TICK && cyc < 20 * TICK) rate_cnt++;
    end
  end

  // Driver
  initial begin
    repeat (4) @(negedge clk);
    check(!ref_req && !ref_urgent && !ref_busy && !cmd_ref && !cke_keep,
          "R1 reset outputs", {ref_req, ref_urgent, ref_busy, cmd_ref, cke_keep}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ref_req && !ref_urgent && !ref_busy && !cmd_ref, "R1 after release",
          {ref_req, ref_urgent, ref_busy, cmd_ref}, 0);

    // R5: grant with nothing owed
    wait_to(9);   ref_gnt = 1'b1;
    wait_to(20);  ref_gnt = 1'b0;
    check(!ref_req, "R5 idle grant", ref_req, 0);

    wait_to(TICK - 1);
    check(!ref_req, "R2 before first tick", ref_req, 0);
    wait_to(TICK);
    check(ref_req && !ref_urgent, "R2 first tick", {ref_req, ref_urgent}, 2);

    wait_to(8 * TICK - 1);
    check(ref_req && !ref_urgent, "R3 polite at 7", {ref_req, ref_urgent}, 2);
    wait_to(8 * TICK);
    check(ref_urgent, "R3 urgent at 8", ref_urgent, 1);

    // Drain after saturation: 9 owed, spaced TRFC+1; then one per tick
    for (int j = 0; j < 9; j++) exp_q.push_back(10 * TICK + 3 + j * (TRFC + 1));
    for (int k = 0; k < 9; k++) exp_q.push_back(11 * TICK + 1 + k * TICK);
    wait_to(10 * TICK + 2);  ref_gnt = 1'b1;
    wait_to(10 * TICK + 3);
    check(ref_busy && cke_keep, "R6 busy on strobe", {ref_busy, cke_keep}, 3);
    check(ref_urgent, "R3 urgent at 8 after take", ref_urgent, 1);
    wait_to(10 * TICK + 2 + TRFC);
    check(ref_busy && !ref_req, "R6 busy last cycle", {ref_busy, ref_req}, 2);
    wait_to(10 * TICK + 3 + TRFC);
    check(!ref_busy && ref_req, "R6 busy released", {ref_busy, ref_req}, 1);
    wait_to(10 * TICK + 4 + TRFC);
    check(!ref_urgent, "R3 polite at 7 after take", ref_urgent, 0);

    // Tick and take on the same edge, then drain two
    wait_to(19 * TICK + 50);  ref_gnt = 1'b0;
    exp_q.push_back(22 * TICK);
    exp_q.push_back(22 * TICK + 50);
    exp_q.push_back(22 * TICK + 50 + TRFC + 1);
    wait_to(22 * TICK - 1);  ref_gnt = 1'b1;
    wait_to(22 * TICK);      ref_gnt = 1'b0;
    wait_to(22 * TICK + 49); ref_gnt = 1'b1;
    wait_to(22 * TICK + 50 + 2 * (TRFC + 1));
    check(!ref_req, "R7 count after tick+take drained", ref_req, 0);
    wait_to(22 * TICK + 90); ref_gnt = 1'b0;
    wait_to(22 * TICK + 95);

    check(exp_q.size() == 0, "R4 all strobes seen", exp_q.size(), 0);
    check(rate_cnt == 9, "R8 one per interval", rate_cnt, 9);
    finish_run();
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog at cycle %0d: actual=%0d expected=%0d", cyc, 1, 0);
    finish_run();
  end

endmodule